// File: doc/BRIEF.md
# Four-Input Converter Sequencer with Range-Gate Start

This block drives an external 10-bit converter that has a parallel bus and four multiplexed analog inputs. It runs one acquisition per range-gate period. A range-gate pulse opens an acceptance window, and the length of that window follows a long/short range mode. The first rising edge of the sample-start input inside the window begins the acquisition. The controller then pulls chip select low and raises its active flag.

Each acquisition begins by writing two different configuration words to the converter. A two-bit write index tracks which write is in progress. The controller then serves four conversions, one per channel in a fixed rotation. For each one it waits for the converter's active-low done flag, reads the result with a read strobe, and waits for the converter to release the flag. Every result leaves the block as a one-cycle valid pulse carrying the 10-bit sample and a 2-bit channel tag. The controller returns to idle after the fourth channel. It also returns to idle, with an error flag set, if the converter stops responding.

The three asynchronous inputs (start, range gate and done flag) each pass through a two-stage synchronizer before any logic uses them.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A rising edge on `smp_start_a` that is accepted makes `conv_cs_n` low and `acq_active` high at the third rising clock edge after the input rises. Both hold until the acquisition ends.
- R2: A start edge is accepted only while the controller is idle and within the acceptance window. The window is `WIN_SHORT` cycles long when `range_long` is 0 and `WIN_LONG` cycles when it is 1, and it opens at the synchronized rising edge of `rgate_a`. An accepted start closes the window, so a range gate admits at most one acquisition.
- R3: Each acquisition begins with exactly two low pulses on `conv_wr_n`. The bus carries `CFG0` during the first pulse and `CFG1` during the second.
- R4: Every `conv_wr_n` and `conv_rd_n` low pulse lasts exactly `STROBE_LEN` cycles. The two strobes are never low together, and at least one cycle with both high separates any two strobes.
- R5: The controller drives `conv_db` only while `conv_wr_n` is low. At all other times, including reset, it leaves the bus high-impedance.
- R6: After the synchronized done flag goes low, the controller issues one read pulse. The bus value during the last low cycle of that pulse appears on `sample_data`, with `sample_valid` high for exactly the first cycle in which `conv_rd_n` is high again.
- R7: The four samples of an acquisition carry channel tags 0, 1, 2 and 3, in that order. After the fourth sample `conv_cs_n` returns high and no further strobes occur until another start is accepted.
- R8: If the done flag does not reach the expected level within `TIMEOUT` cycles of waiting, `timeout_err` rises, `conv_cs_n` goes high and strobing stops. The next accepted start clears `timeout_err`.
- R9: After each read, the controller waits for the done flag to return high before it waits for the next conversion. A flag that stays low for a while after a read never causes a second read of the same conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_start_a | input | 1 | Asynchronous sample-start pulse |
| rgate_a | input | 1 | Asynchronous range-gate pulse |
| range_long | input | 1 | 1 selects the long window, 0 the short one |
| conv_int_n | input | 1 | Asynchronous converter done flag, active low |
| conv_cs_n | output | 1 | Converter chip select, active low |
| conv_wr_n | output | 1 | Configuration write strobe, active low |
| conv_rd_n | output | 1 | Result read strobe, active low |
| conv_db | inout | DW | Converter data bus |
| acq_active | output | 1 | Acquisition in progress (start flag) |
| sample_valid | output | 1 | One-cycle sample strobe |
| sample_data | output | DW | Sample value |
| sample_chan | output | 2 | Channel tag of the sample |
| timeout_err | output | 1 | Converter failed to respond in time |

## Verification
A write index that is off by one shows up during the configuration writes. Either the wrong word appears during a write pulse, or the number of write pulses differs from two. Both are visible within the first few strobes after chip select falls. A channel state that is skipped or repeated shows up as a wrong tag or a wrong sample count on the valid output, no later than the end of that acquisition. A lost release wait appears as a fifth read pulse. A broken timeout shows up as chip select staying low, or falling early, within `TIMEOUT` cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CH0  = 3'd1,
    ST_CH1  = 3'd2,
    ST_CH2  = 3'd3,
    ST_CH3  = 3'd4
  } acq_state_t;

  typedef enum logic [2:0] {
    PH_WR,
    PH_WGAP,
    PH_WAIT,
    PH_RD,
    PH_REL
  } acq_phase_t;

  // fixed channel rotation; last channel leads back to idle
  function automatic acq_state_t chan_after(input acq_state_t s);
    case (s)
      ST_CH0:  return ST_CH1;
      ST_CH1:  return ST_CH2;
      ST_CH2:  return ST_CH3;
      default: return ST_IDLE;
    endcase
  endfunction

  function automatic logic [1:0] chan_tag(input acq_state_t s);
    case (s)
      ST_CH1:  return 2'd1;
      ST_CH2:  return 2'd2;
      ST_CH3:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic int win_cycles(input logic long_mode, input int short_len,
                                    input int long_len);
    return long_mode ? long_len : short_len;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/adc_seq_window.sv
module adc_seq_window
  import adc_seq_pkg::*;
#(
  parameter int WIN_SHORT = 51200,
  parameter int WIN_LONG  = 102400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_s,
  input  logic range_long,
  input  logic start_s,
  input  logic consume,
  output logic start_rise,
  output logic win_open
);
  localparam int CW = $clog2(max2(WIN_SHORT, WIN_LONG) + 1);

  logic          gate_d, start_d;
  logic [CW-1:0] wcnt;
  logic          gate_rise;

  assign gate_rise  = gate_s & ~gate_d;
  assign start_rise = start_s & ~start_d;
  assign win_open   = (wcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d  <= 1'b0;
      start_d <= 1'b0;
      wcnt    <= '0;
    end else begin
      gate_d  <= gate_s;
      start_d <= start_s;
      if (gate_rise)
        wcnt <= CW'(win_cycles(range_long, WIN_SHORT, WIN_LONG));
      else if (consume)
        wcnt <= '0;
      else if (wcnt != '0)
        wcnt <= wcnt - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int DW         = 10,
  parameter int STROBE_LEN = 2,
  parameter int GAP_LEN    = 1,
  parameter int TIMEOUT    = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          int_s,
  input  logic [DW-1:0] bus_in,
  output logic          idle,
  output logic [1:0]    wr_idx,
  output logic          rd_done,
  output logic          cs_n,
  output logic          wr_n,
  output logic          rd_n,
  output logic          sample_valid,
  output logic [DW-1:0] sample_data,
  output logic [1:0]    sample_chan,
  output logic          timeout_err
);
  localparam int SCW = $clog2(max2(STROBE_LEN, GAP_LEN) + 1);
  localparam int TCW = $clog2(TIMEOUT + 1);

  acq_state_t     state;
  acq_phase_t     phase;
  logic [SCW-1:0] scnt;
  logic [TCW-1:0] tcnt;
  logic           strobe_end, gap_end, waited_out;

  assign idle       = (state == ST_IDLE);
  assign strobe_end = (scnt == SCW'(STROBE_LEN - 1));
  assign gap_end    = (scnt == SCW'(GAP_LEN - 1));
  assign waited_out = (tcnt == TCW'(TIMEOUT - 1));
  assign cs_n       = idle;
  assign wr_n       = ~(!idle && phase == PH_WR);
  assign rd_n       = ~(!idle && phase == PH_RD);
  assign rd_done    = !idle && phase == PH_RD && strobe_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      phase        <= PH_WAIT;
      scnt         <= '0;
      tcnt         <= '0;
      wr_idx       <= 2'd0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      sample_chan  <= 2'd0;
      timeout_err  <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (state == ST_IDLE) begin
        if (accept) begin
          state       <= ST_CH0;
          phase       <= PH_WR;
          scnt        <= '0;
          wr_idx      <= 2'd0;
          timeout_err <= 1'b0;
        end
      end else begin
        case (phase)
          PH_WR: begin
            if (strobe_end) begin
              scnt   <= '0;
              wr_idx <= wr_idx + 2'd1;
              phase  <= PH_WGAP;
            end else scnt <= scnt + 1'b1;
          end
          PH_WGAP: begin
            if (gap_end) begin
              scnt  <= '0;
              tcnt  <= '0;
              phase <= (wr_idx == 2'd2) ? PH_WAIT : PH_WR;
            end else scnt <= scnt + 1'b1;
          end
          PH_WAIT: begin
            if (!int_s) begin
              phase <= PH_RD;
              scnt  <= '0;
            end else if (waited_out) begin
              timeout_err <= 1'b1;
              state       <= ST_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_RD: begin
            if (strobe_end) begin
              sample_data  <= bus_in;
              sample_chan  <= chan_tag(state);
              sample_valid <= 1'b1;
              phase        <= PH_REL;
              tcnt         <= '0;
            end else scnt <= scnt + 1'b1;
          end
          default: begin // PH_REL: wait for done flag release
            if (int_s) begin
              state <= chan_after(state);
              phase <= PH_WAIT;
              tcnt  <= '0;
            end else if (waited_out) begin
              timeout_err <= 1'b1;
              state       <= ST_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int            DW         = 10,
  parameter logic [DW-1:0] CFG0       = 10'h2C5,
  parameter logic [DW-1:0] CFG1       = 10'h13A,
  parameter int            STROBE_LEN = 2,
  parameter int            GAP_LEN    = 1,
  parameter int            TIMEOUT    = 4096,
  parameter int            WIN_SHORT  = 51200,
  parameter int            WIN_LONG   = 102400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_start_a,
  input  logic          rgate_a,
  input  logic          range_long,
  input  logic          conv_int_n,
  output logic          conv_cs_n,
  output logic          conv_wr_n,
  output logic          conv_rd_n,
  inout  wire  [DW-1:0] conv_db,
  output logic          acq_active,
  output logic          sample_valid,
  output logic [DW-1:0] sample_data,
  output logic [1:0]    sample_chan,
  output logic          timeout_err
);
  logic          start_s, gate_s, int_s;
  logic          start_rise, win_open, idle, accept, rd_done;
  logic [1:0]    wr_idx;
  logic [DW-1:0] cfg_word;

  adc_seq_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({smp_start_a, rgate_a, conv_int_n}),
    .q({start_s, gate_s, int_s})
  );

  adc_seq_window #(.WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG)) u_win (
    .clk(clk), .rst_n(rst_n), .gate_s(gate_s), .range_long(range_long),
    .start_s(start_s), .consume(accept), .start_rise(start_rise),
    .win_open(win_open)
  );

  assign accept = start_rise & win_open & idle;

  adc_seq_fsm #(.DW(DW), .STROBE_LEN(STROBE_LEN), .GAP_LEN(GAP_LEN),
                .TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .int_s(int_s),
    .bus_in(conv_db), .idle(idle), .wr_idx(wr_idx), .rd_done(rd_done),
    .cs_n(conv_cs_n), .wr_n(conv_wr_n), .rd_n(conv_rd_n),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .sample_chan(sample_chan), .timeout_err(timeout_err)
  );

  assign cfg_word   = (wr_idx == 2'd0) ? CFG0 : CFG1;
  assign conv_db    = conv_wr_n ? {DW{1'bz}} : cfg_word;
  assign acq_active = ~idle;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic rd_done,
  input logic conv_cs_n,
  input logic conv_wr_n,
  input logic conv_rd_n,
  input logic sample_valid,
  input logic timeout_err
);
  a_r1_cs_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !conv_cs_n);

  a_r3_wr_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_wr_n |-> !conv_cs_n);

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    conv_wr_n || conv_rd_n);

  a_r4_idle_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_wr_n) || $fell(conv_rd_n)) |-> ($past(conv_wr_n) && $past(conv_rd_n)));

  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (sample_valid && conv_rd_n));

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  a_r8_error_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (conv_cs_n && conv_wr_n && conv_rd_n));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .rd_done(rd_done),
  .conv_cs_n(conv_cs_n), .conv_wr_n(conv_wr_n), .conv_rd_n(conv_rd_n),
  .sample_valid(sample_valid), .timeout_err(timeout_err)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int SL = 3, GL = 2, TO = 40, WS = 40, WL = 200;
  localparam logic [9:0] C0 = 10'h2C5, C1 = 10'h13A;
  // {d3,d2,d1,d0, conversion delay, release delay}
  localparam logic [47:0] VEC [4] = '{
    {10'h3FF, 10'h000, 10'h155, 10'h2AA, 4'd6,  4'd1},
    {10'h001, 10'h200, 10'h3FE, 10'h0F0, 4'd9,  4'd3},
    {10'h123, 10'h321, 10'h0AB, 10'h3C3, 4'd12, 4'd8},
    {10'h2F0, 10'h10F, 10'h05A, 10'h1A5, 4'd5,  4'd2}
  };

  logic clk = 0, rst_n = 0, start_a = 0, gate_a = 0, rlong = 0, int_n = 1;
  wire  [9:0] db;
  wire        cs_n, wr_n, rd_n, act, vld, err;
  wire  [9:0] sdata;
  wire  [1:0] schan;
  logic [9:0] adc_word = '0;
  assign db = rd_n ? 10'bz : adc_word;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.DW(10), .CFG0(C0), .CFG1(C1), .STROBE_LEN(SL), .GAP_LEN(GL),
                 .TIMEOUT(TO), .WIN_SHORT(WS), .WIN_LONG(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_start_a(start_a), .rgate_a(gate_a),
    .range_long(rlong), .conv_int_n(int_n), .conv_cs_n(cs_n), .conv_wr_n(wr_n),
    .conv_rd_n(rd_n), .conv_db(db), .acq_active(act), .sample_valid(vld),
    .sample_data(sdata), .sample_chan(schan), .timeout_err(err)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] a,
                     input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // converter model state
  logic [39:0] cur_data = '0;
  int   conv_dly = 5, rel_dly = 1;
  bit   no_int = 0, conv_on = 0, rel_on = 0;
  int   conv_left = 0, rel_left = 0;
  int   wr_cnt = 0, rd_cnt = 0, rd_started = 0, vcnt = 0, got_n = 0;
  int   wr_len = 0, rd_len = 0;
  logic [9:0] wr_last = '0;
  logic [9:0] wr_words [2];
  logic [9:0] got_d [4];
  logic [1:0] got_c [4];
  bit   bad_w = 0, bad_gap = 0, bad_z = 0, bad_v = 0, cs_seen = 0;
  logic prev_wr = 1, prev_rd = 1;

  task automatic clr_model();
    conv_on = 0; rel_on = 0; int_n = 1;
    wr_cnt = 0; rd_cnt = 0; rd_started = 0; vcnt = 0; got_n = 0;
    wr_len = 0; rd_len = 0;
    bad_w = 0; bad_gap = 0; bad_z = 0; bad_v = 0; cs_seen = 0;
    for (int k = 0; k < 4; k++) begin got_d[k] = '0; got_c[k] = '0; end
    wr_words[0] = '0; wr_words[1] = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) cs_seen = 1;
      if (!wr_n && !rd_n) bad_gap = 1;
      if ((!wr_n && !prev_rd) || (!rd_n && !prev_wr)) bad_gap = 1;
      if (wr_n && rd_n && db !== 10'bz) bad_z = 1;
      if (vld) vcnt++;
      if (conv_on) begin
        if (conv_left == 0) begin int_n = 0; conv_on = 0; end
        else conv_left--;
      end
      if (rel_on) begin
        if (rel_left == 0) begin
          int_n = 1; rel_on = 0;
          if (rd_started < 4) begin conv_on = 1; conv_left = conv_dly; end
        end else rel_left--;
      end
      if (!wr_n) begin wr_len++; wr_last = db; end
      if (wr_n && !prev_wr) begin
        if (wr_cnt < 2) wr_words[wr_cnt] = wr_last;
        if (wr_len != SL) bad_w = 1;
        wr_cnt++; wr_len = 0;
        if (wr_cnt == 2 && !no_int) begin conv_on = 1; conv_left = conv_dly; end
      end
      if (!rd_n) begin
        if (prev_rd) begin
          if (rd_started < 4) adc_word = cur_data[rd_started*10 +: 10];
          rd_started++; rel_on = 1; rel_left = rel_dly;
        end
        rd_len++;
      end
      if (rd_n && !prev_rd) begin
        rd_cnt++;
        if (rd_len != SL) bad_w = 1;
        rd_len = 0;
        if (!vld) bad_v = 1;
        else if (got_n < 4) begin got_d[got_n] = sdata; got_c[got_n] = schan; got_n++; end
      end
      prev_wr = wr_n; prev_rd = rd_n;
    end
  end

  task automatic acq(input logic [47:0] v, input bit rsel, input int gap,
                     input bit new_gate, input bit expect_go, input bit silent);
    clr_model();
    no_int   = silent;
    cur_data = v[47:8];
    conv_dly = int'(v[7:4]);
    rel_dly  = int'(v[3:0]);
    if (new_gate) begin
      @(negedge clk); rlong = rsel; gate_a = 1;
      repeat (2) @(negedge clk);
      gate_a = 0;
    end
    repeat (gap) @(negedge clk);
    start_a = 1;
    if (expect_go) begin
      @(negedge clk);
      @(negedge clk);
      chk(cs_n == 1'b1, "R1 cs early", 32'(cs_n), 1);
      @(negedge clk);
      chk(cs_n == 1'b0 && act == 1'b1, "R1 cs at third edge", 32'({cs_n, act}), 32'b01);
      chk(err == 1'b0, "R8 error cleared by start", 32'(err), 0);
      start_a = 0;
      for (int k = 0; k < 3000; k++) begin
        @(negedge clk);
        if (cs_n) break;
      end
    end else begin
      repeat (3) @(negedge clk);
      start_a = 0;
      repeat (30) @(negedge clk);
      chk(cs_seen == 0, "R2 start outside window ignored", 32'(cs_seen), 0);
    end
  endtask

  task automatic check_full(input logic [47:0] v);
    chk(wr_cnt == 2, "R3 write count", 32'(wr_cnt), 2);
    chk(wr_words[0] == C0, "R3 first word", 32'(wr_words[0]), 32'(C0));
    chk(wr_words[1] == C1, "R3 second word", 32'(wr_words[1]), 32'(C1));
    chk(bad_w == 0, "R4 strobe width", 32'(bad_w), 0);
    chk(bad_gap == 0, "R4 strobe separation", 32'(bad_gap), 0);
    chk(bad_z == 0, "R5 bus released", 32'(bad_z), 0);
    chk(vcnt == 4 && bad_v == 0, "R6 valid pulses", 32'(vcnt), 4);
    chk(rd_cnt == 4, "R9 one read per conversion", 32'(rd_cnt), 4);
    for (int k = 0; k < 4; k++) begin
      chk(got_d[k] == v[8 + k*10 +: 10], "R6 sample data", 32'(got_d[k]),
          32'(v[8 + k*10 +: 10]));
      chk(got_c[k] == 2'(k), "R7 channel order", 32'(got_c[k]), 32'(k));
    end
    chk(cs_n == 1'b1 && act == 1'b0, "R7 idle after last channel", 32'(cs_n), 1);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 4 && wr_cnt == 2 && cs_n, "R7 quiet until next start", 32'(rd_cnt), 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n, "R4 strobes high in reset", 32'({cs_n, wr_n, rd_n}), 32'b111);
    chk(!vld && !err && !act, "R6 outputs quiet in reset", 32'({vld, err, act}), 0);
    chk(db === 10'bz, "R5 bus released in reset", 32'(db), 32'h3FF);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // table walk: one full acquisition per vector, alternating range mode
    for (int i = 0; i < 4; i++) begin
      acq(VEC[i], i[0], 5, 1, 1, 0);
      check_full(VEC[i]);
    end

    // R2: short window already expired
    acq(VEC[0], 0, 60, 1, 0, 0);
    // R2: long window still open at the same distance
    acq(VEC[1], 1, 60, 1, 1, 0);
    check_full(VEC[1]);
    // R2: second start in the same gate period is ignored
    acq(VEC[1], 1, 5, 0, 0, 0);

    // R8: converter never finishes
    acq(VEC[2], 0, 5, 1, 1, 1);
    chk(err == 1'b1, "R8 timeout flag", 32'(err), 1);
    chk(cs_n == 1'b1 && rd_cnt == 0, "R8 idle without reads", 32'(rd_cnt), 0);
    repeat (10) @(negedge clk);
    chk(err == 1'b1 && cs_n, "R8 flag holds", 32'(err), 1);
    // next good acquisition clears the flag (checked inside acq)
    acq(VEC[3], 1, 5, 1, 1, 0);
    check_full(VEC[3]);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule